// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a behavioural synchronous static RAM with a flow-through read path. On each rising clock edge it can register an external address. A 2-bit burst counter then supplies the low address bits, so four word positions can be reached from one loaded address. Read data comes straight from the registered address through the array, without a second output register. The first word of a burst is therefore on the bus in the cycle that follows the address edge, and each further word follows one cycle later.

Two start strobes can begin a burst. One strobe is meant for a processor and is gated by the first chip select. The other is meant for a cache controller and is always honoured. A separate step input moves the counter forward. A mode input picks linear or interleaved count order. A write can update every lane at once, or only the byte lanes selected in byte-write mode. Each word is made of 9-bit lanes, and the ninth bit of each lane holds parity.

A sleep input freezes the block and turns the output drive off, and the stored contents are kept. The output enable also acts without waiting for a clock edge. The data bus is split into a write path, a read path and a drive-enable output, and the drive enable controls an external pad buffer.

Top module: `fts_sram`

## Requirements
- R1: A start strobe that is taken at an edge while the device is selected loads addr_i, resets the burst count and starts an access. The word at that address is on rdata_o, with dq_oe_o high, in the cycle that directly follows that edge.
- R2: A start strobe that is taken overrides stepping. The new address wins even if step_ni is low at the same edge.
- R3: With no strobe taken, the burst address moves to the next position only at edges where step_ni is low. Otherwise it holds.
- R4: When ilv_i = 0 (linear order), the two low address bits equal the start bits plus the count, modulo 4. Address bits above bit 1 never change during a burst.
- R5: When ilv_i = 1 (interleaved order), the two low address bits equal the start bits XOR the count (0, 1, 2, 3).
- R6: A write with wr_all_ni low updates every lane, whatever the values of wr_en_ni and lane_we_ni.
- R7: A write with wr_all_ni high updates lane k (bits 9k+8 down to 9k) only when wr_en_ni is low and lane_we_ni[k] is low. With wr_en_ni high, nothing is written.
- R8: Write data is sampled at an edge after the load edge, into the current burst word. The step taken at the same edge then applies after the write.
- R9: The device is selected only when cs1_ni is low, cs2_i is high and cs3_ni is low. A strobe that is taken while the device is deselected ends the access and forces dq_oe_o low.
- R10: cpu_strobe_ni is ignored while cs1_ni is high.
- R11: While sleep_i is high, dq_oe_o is low at once. No edge changes the burst state or writes the array, and the stored contents are kept.
- R12: With an access active, dq_oe_o follows the inverse of oe_ni without waiting for a clock edge.
- R13: During reset and right after it, no access is active and dq_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| cs1_ni | input | 1 | Chip select 1, active low; also gates cpu_strobe_ni |
| cs2_i | input | 1 | Chip select 2, active high |
| cs3_ni | input | 1 | Chip select 3, active low |
| cpu_strobe_ni | input | 1 | Processor-side burst start, active low |
| ctl_strobe_ni | input | 1 | Controller-side burst start, active low |
| step_ni | input | 1 | Burst advance, active low |
| ilv_i | input | 1 | Count order: 1 interleaved, 0 linear |
| wr_all_ni | input | 1 | Write all lanes, active low |
| wr_en_ni | input | 1 | Byte-write enable, active low |
| lane_we_ni | input | LANES | Per-lane write select, active low |
| wdata_i | input | LANES*9 | Write data, lane k in bits 9k+8:9k |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high, asynchronous on output |
| rdata_o | output | LANES*9 | Read data, zero when not driven |
| dq_oe_o | output | 1 | Drive enable for the external data pads |

## Verification
The bench builds the block with ADDR_W = 5 and two lanes. With those values the whole 32-word array can be written through aligned linear bursts, and then read back from any start offset. That makes linear wrap-around, interleaved XOR ordering and the stability of the upper address bits visible in the data itself. With two lanes, one lane can be written while the other is left alone. The same setup covers holding on a missing step, strobe priority, both deselect paths, and sleep, where state and contents must survive.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int unsigned LANE_W = 9;

  // low burst address bits from start bits and 2-bit count
  function automatic logic [1:0] burst_off(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              load_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_ni,
  input  logic              ilv_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              active_o
);
  import fts_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!hold_i) begin
      if (load_i) begin
        base_q   <= addr_i;
        cnt_q    <= '0;
        active_q <= sel_i;
      end else if (active_q && !step_ni) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign cur_addr_o = {base_q[ADDR_W-1:2], burst_off(base_q[1:0], cnt_q, ilv_i)};
  assign active_o   = active_q;
endmodule

// File: rtl/fts_lane_dec.sv
module fts_lane_dec #(
  parameter int unsigned LANES = 2
) (
  input  logic             wr_all_ni,
  input  logic             wr_en_ni,
  input  logic [LANES-1:0] lane_we_ni,
  output logic [LANES-1:0] lane_mask_o
);
  always_comb begin
    if (!wr_all_ni)     lane_mask_o = '1;
    else if (!wr_en_ni) lane_mask_o = ~lane_we_ni;
    else                lane_mask_o = '0;
  end
endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2
) (
  input  logic                              clk_i,
  input  logic [LANES-1:0]                  we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [LANES*fts_pkg::LANE_W-1:0]  wdata_i,
  output logic [LANES*fts_pkg::LANE_W-1:0]  rdata_o
);
  import fts_pkg::*;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             cs1_ni,
  input  logic                             cs2_i,
  input  logic                             cs3_ni,
  input  logic                             cpu_strobe_ni,
  input  logic                             ctl_strobe_ni,
  input  logic                             step_ni,
  input  logic                             ilv_i,
  input  logic                             wr_all_ni,
  input  logic                             wr_en_ni,
  input  logic [LANES-1:0]                 lane_we_ni,
  input  logic [LANES*fts_pkg::LANE_W-1:0] wdata_i,
  input  logic                             oe_ni,
  input  logic                             sleep_i,
  output logic [LANES*fts_pkg::LANE_W-1:0] rdata_o,
  output logic                             dq_oe_o
);
  import fts_pkg::*;
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              sel, load, active;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_mask, lane_we;
  logic [DATA_W-1:0] arr_q;

  assign sel  = !cs1_ni && cs2_i && !cs3_ni;
  // processor strobe is gated by the first chip select
  assign load = (!cpu_strobe_ni && !cs1_ni) || !ctl_strobe_ni;

  fts_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (sleep_i),
    .load_i     (load),
    .sel_i      (sel),
    .addr_i     (addr_i),
    .step_ni    (step_ni),
    .ilv_i      (ilv_i),
    .cur_addr_o (cur_addr),
    .active_o   (active)
  );

  fts_lane_dec #(.LANES(LANES)) u_dec (
    .wr_all_ni   (wr_all_ni),
    .wr_en_ni    (wr_en_ni),
    .lane_we_ni  (lane_we_ni),
    .lane_mask_o (lane_mask)
  );

  assign lane_we = (active && !sleep_i) ? lane_mask : '0;

  fts_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
    .clk_i   (clk_i),
    .we_i    (lane_we),
    .addr_i  (cur_addr),
    .wdata_i (wdata_i),
    .rdata_o (arr_q)
  );

  assign dq_oe_o = active && !oe_ni && !sleep_i;
  assign rdata_o = dq_oe_o ? arr_q : '0;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              step_ni,
  input logic              ilv_i,
  input logic              cs1_ni,
  input logic              ctl_strobe_ni,
  input logic              wr_all_ni,
  input logic              load,
  input logic              active,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LANES-1:0]  lane_mask,
  input logic              dq_oe_o
);
  assert_reset_idle_R13: assert property (@(posedge clk_i)
    !rst_ni |-> !dq_oe_o);

  assert_sleep_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);

  assert_sleep_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(active) && (ilv_i != $past(ilv_i) || $stable(cur_addr))));

  assert_step_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !load && step_ni) |=> (ilv_i != $past(ilv_i) || $stable(cur_addr)));

  assert_linear_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !load && active && !step_ni && !ilv_i)
      |=> (ilv_i || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  assert_upper_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load) |=> $stable(cur_addr[ADDR_W-1:2]));

  assert_cpu_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs1_ni && ctl_strobe_ni) |-> !load);

  assert_global_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_all_ni |-> (&lane_mask));
endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sleep_i       (sleep_i),
  .step_ni       (step_ni),
  .ilv_i         (ilv_i),
  .cs1_ni        (cs1_ni),
  .ctl_strobe_ni (ctl_strobe_ni),
  .wr_all_ni     (wr_all_ni),
  .load          (load),
  .active        (active),
  .cur_addr      (cur_addr),
  .lane_mask     (lane_mask),
  .dq_oe_o       (dq_oe_o)
);

// File: tb/fts_sram_test.sv
`timescale 1ns/1ps
module fts_sram_test;
  localparam int AW = 5;
  localparam int LN = 2;
  localparam int DW = LN * 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic cs1_ni = 1'b0, cs2_i = 1'b1, cs3_ni = 1'b0;
  logic cpu_strobe_ni = 1'b1, ctl_strobe_ni = 1'b1, step_ni = 1'b1, ilv_i = 1'b0;
  logic wr_all_ni = 1'b1, wr_en_ni = 1'b1;
  logic [LN-1:0] lane_we_ni = '1;
  logic [DW-1:0] wdata_i = '0;
  logic oe_ni = 1'b0, sleep_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic dq_oe_o;

  logic [DW-1:0] sh [DEPTH];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fts_sram #(.ADDR_W(AW), .LANES(LN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .cs1_ni(cs1_ni), .cs2_i(cs2_i),
    .cs3_ni(cs3_ni), .cpu_strobe_ni(cpu_strobe_ni), .ctl_strobe_ni(ctl_strobe_ni),
    .step_ni(step_ni), .ilv_i(ilv_i), .wr_all_ni(wr_all_ni), .wr_en_ni(wr_en_ni),
    .lane_we_ni(lane_we_ni), .wdata_i(wdata_i), .oe_ni(oe_ni), .sleep_i(sleep_i),
    .rdata_o(rdata_o), .dq_oe_o(dq_oe_o)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return {9'(a * 3 + 1), 9'(a ^ 9'h155)};
  endfunction

  function automatic logic [AW-1:0] badr(input logic [AW-1:0] a, input int i, input logic ilv);
    logic [1:0] c = 2'(i);
    return {a[AW-1:2], ilv ? (a[1:0] ^ c) : (a[1:0] + c)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input logic ilv);
    ilv_i = ilv; addr_i = a; ctl_strobe_ni = 1'b0;
    tick;
    ctl_strobe_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] w = badr(a, i, ilv);
      wr_all_ni = 1'b0; step_ni = 1'b0; wdata_i = pat(int'(w));
      sh[w] = pat(int'(w));
      tick;
    end
    wr_all_ni = 1'b1; step_ni = 1'b1;
  endtask

  task automatic rd_burst(input logic [AW-1:0] a, input logic ilv, input bit use_cpu, input string req);
    ilv_i = ilv; addr_i = a;
    if (use_cpu) cpu_strobe_ni = 1'b0; else ctl_strobe_ni = 1'b0;
    tick;
    cpu_strobe_ni = 1'b1; ctl_strobe_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check(req, 32'(rdata_o), 32'(sh[badr(a, i, ilv)]));
      step_ni = 1'b0;
      tick;
    end
    step_ni = 1'b1;
  endtask

  task automatic load(input logic [AW-1:0] a);
    addr_i = a; ctl_strobe_ni = 1'b0; tick; ctl_strobe_ni = 1'b1;
  endtask

  task automatic t_reset;
    #1; check("R13 idle in reset", 32'(dq_oe_o), 0);
    @(negedge clk); rst_ni = 1'b1; tick;
    check("R13 idle after reset", 32'(dq_oe_o), 0);
  endtask

  task automatic t_fill;  // R6 R8: aligned linear write bursts cover the array
    for (int b = 0; b < DEPTH; b += 4) wr_burst(AW'(b), 1'b0);
  endtask

  task automatic t_orders;
    rd_burst(5'd14, 1'b0, 1'b1, "R1 R4 R8 linear wrap via cpu strobe");
    check("R1 drive on", 32'(dq_oe_o), 1);
    rd_burst(5'd9, 1'b1, 1'b0, "R5 interleaved from offset 1");
    rd_burst(5'd23, 1'b1, 1'b1, "R5 interleaved from offset 3");
    wr_burst(5'd18, 1'b1);
    rd_burst(5'd18, 1'b1, 1'b0, "R5 R8 interleaved write then read");
    ilv_i = 1'b0;
  endtask

  task automatic t_hold_prio;
    load(5'd6);
    check("R1 first word", 32'(rdata_o), 32'(sh[6]));
    tick; tick;
    check("R3 hold without step", 32'(rdata_o), 32'(sh[6]));
    step_ni = 1'b0; tick;
    check("R3 step", 32'(rdata_o), 32'(sh[7]));
    addr_i = 5'd17; ctl_strobe_ni = 1'b0; tick;
    ctl_strobe_ni = 1'b1; step_ni = 1'b1;
    check("R2 strobe over step", 32'(rdata_o), 32'(sh[17]));
  endtask

  task automatic t_writes;
    load(5'd3);
    wr_en_ni = 1'b0; lane_we_ni = 2'b01; wdata_i = 18'h3ffff; tick;
    sh[3] = {9'h1ff, sh[3][8:0]};
    wr_en_ni = 1'b1; lane_we_ni = 2'b11;
    check("R7 upper lane only", 32'(rdata_o), 32'(sh[3]));
    wdata_i = '0; lane_we_ni = 2'b00; tick;
    check("R7 no write without enable", 32'(rdata_o), 32'(sh[3]));
    wr_en_ni = 1'b0; lane_we_ni = 2'b11; tick;
    check("R7 no lane selected", 32'(rdata_o), 32'(sh[3]));
    wr_en_ni = 1'b1; wr_all_ni = 1'b0; wdata_i = 18'h0aaaa; tick;
    sh[3] = 18'h0aaaa; wr_all_ni = 1'b1;
    check("R6 global over masked lanes", 32'(rdata_o), 32'(sh[3]));
  endtask

  task automatic t_select;
    load(5'd20);
    cs1_ni = 1'b1; cpu_strobe_ni = 1'b0; addr_i = 5'd1; tick;
    cpu_strobe_ni = 1'b1; cs1_ni = 1'b0;
    check("R10 cpu strobe ignored", 32'(rdata_o), 32'(sh[20]));
    check("R10 still driving", 32'(dq_oe_o), 1);
    cs2_i = 1'b0; load(5'd2); cs2_i = 1'b1;
    check("R9 deselect drive off", 32'(dq_oe_o), 0);
    cs3_ni = 1'b1; load(5'd2); cs3_ni = 1'b0;
    check("R9 deselect by cs3", 32'(dq_oe_o), 0);
    load(5'd2);
    check("R9 reselect data", 32'(rdata_o), 32'(sh[2]));
  endtask

  task automatic t_async;
    oe_ni = 1'b1; #1;
    check("R12 oe off", 32'(dq_oe_o), 0);
    oe_ni = 1'b0; #1;
    check("R12 oe on", 32'(dq_oe_o), 1);
    sleep_i = 1'b1; #1;
    check("R11 sleep drive off", 32'(dq_oe_o), 0);
    wr_all_ni = 1'b0; wdata_i = '0; step_ni = 1'b0; ctl_strobe_ni = 1'b0; addr_i = 5'd30;
    tick; tick;
    wr_all_ni = 1'b1; step_ni = 1'b1; ctl_strobe_ni = 1'b1;
    sleep_i = 1'b0; #1;
    check("R11 wake drive", 32'(dq_oe_o), 1);
    check("R11 state and contents kept", 32'(rdata_o), 32'(sh[2]));
    load(5'd30);
    check("R11 no write during sleep", 32'(rdata_o), 32'(sh[30]));
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run;
  end

  initial begin
    t_reset;
    t_fill;
    t_orders;
    t_hold_prio;
    t_writes;
    t_select;
    t_async;
    finish_run;
  end
endmodule